// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Pin Emulator

This block stands in for a byte-wide asynchronous static RAM on a synchronous test bench or inside a prototype, so that a memory controller can be exercised against realistic pin behaviour. Every system clock it samples three active-low strobes (chip select, output enable, write enable), a 19-bit address, an 8-bit write data bus and a controller-side drive-enable flag. It answers with an 8-bit read data bus, a flag that plays the part of the tri-state output driver, and a bus clash flag.

The sampled strobes are decoded into four modes: standby, output-disabled read, driving read and write. A write is stored only when the overlap of chip select low and write enable low ends, whichever of the two strobes rises first, using the address and byte held on the last sample inside the overlap. The memory depth is a parameter so that a bench can use a small array, while the address port keeps its full width.

Top module: `sram_pin_model`

## Requirements
- R1: While reset is high and on the first cycles after it, `rdata_oe`, `rdata` and `bus_clash` are 0; reset ends any write overlap in progress without storing it.
- R2: When `sel_n` is sampled high, the emulator is in standby and `rdata_oe` is 0 whatever `wr_n` and `rd_en_n` are.
- R3: With `sel_n`=0, `wr_n`=1 and `rd_en_n`=0 sampled at a rising edge, the next rising edge sets `rdata_oe`=1 and `rdata` to the byte stored at the sampled address (two edges from input to output).
- R4: With `sel_n`=0, `wr_n`=1 and `rd_en_n`=1, the outputs stay off: `rdata_oe`=0 and `rdata`=0.
- R5: With `sel_n`=0 and `wr_n`=0, `rdata_oe` is 0 even when `rd_en_n` is 0.
- R6: A byte is stored on the first sample where `sel_n` and `wr_n` are no longer both low, whether `wr_n` or `sel_n` rose; the address and data stored are those of the previous sample, so a change of `wdata` on the ending sample is not stored.
- R7: `wr_n` low while `sel_n` is high stores nothing.
- R8: A read sampled on the very cycle that ends a write to the same word returns the newly written byte.
- R9: Only the low log2(DEPTH) address bits select a word (bits 9:0 at the default depth of 1024); higher bits alias.
- R10: `bus_clash` is 1 exactly when `rdata_oe` is 1 and `ctl_drive_en` was sampled high together with the read strobes; it is 0 otherwise.
- R11: Whenever `rdata_oe` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select strobe |
| rd_en_n | input | 1 | Active-low output enable strobe |
| wr_n | input | 1 | Active-low write enable strobe |
| addr | input | 19 | Word address |
| wdata | input | 8 | Write data from the controller |
| ctl_drive_en | input | 1 | Controller is driving the data bus |
| rdata | output | 8 | Read data, zero when not driving |
| rdata_oe | output | 1 | Emulated output driver enable |
| bus_clash | output | 1 | Emulator and controller both drive the bus |

## Verification
The bench targets the write end: overlap closed by write enable with chip select held low, closed by chip select with write enable held low, and write data changing on the closing sample; a design that stores on the falling edge or on the wrong sample would keep the late byte or miss the write entirely. A read of the just-written word on the closing sample catches a design lacking the bypass, which would return the stale byte. Write enable low during standby, an address with high bits set, and a read with output enable low during a write check for false stores, missing aliasing, and a driver that fails to turn off. The clash flag is probed with the controller driving during both a driving read and an output-disabled read.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic              sel_n;
        logic              rd_en_n;
        logic              wr_n;
        logic              ctl_drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pin_sample_t;

    typedef struct packed {
        bus_mode_e         mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } held_sample_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } commit_t;

    localparam pin_sample_t IDLE_PINS = '{
        sel_n:   1'b1,
        rd_en_n: 1'b1,
        wr_n:    1'b1,
        ctl_drv: 1'b0,
        addr:    '0,
        data:    '0
    };

    localparam held_sample_t IDLE_HELD = '{
        mode: MODE_STANDBY,
        addr: '0,
        data: '0
    };

    // Chip select dominates, then write enable, then output enable.
    function automatic bus_mode_e decode_mode(input logic sel_n,
                                              input logic wr_n,
                                              input logic rd_en_n);
        bus_mode_e m;
        if (sel_n)
            m = MODE_STANDBY;
        else if (!wr_n)
            m = MODE_WRITE;
        else if (rd_en_n)
            m = MODE_OUT_OFF;
        else
            m = MODE_READ;
        return m;
    endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
    import sram_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_sample_t       pins_i,
    output bus_mode_e         cur_mode_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              cur_drv_o,
    output held_sample_t      prev_o
);

    pin_sample_t  cur_q;
    held_sample_t prev_q;
    bus_mode_e    cur_mode;

    assign cur_mode = decode_mode(cur_q.sel_n, cur_q.wr_n, cur_q.rd_en_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= IDLE_PINS;
            prev_q <= IDLE_HELD;
        end else begin
            cur_q       <= pins_i;
            prev_q.mode <= cur_mode;
            prev_q.addr <= cur_q.addr;
            prev_q.data <= cur_q.data;
        end
    end

    assign cur_mode_o = cur_mode;
    assign cur_addr_o = cur_q.addr;
    assign cur_drv_o  = cur_q.ctl_drv;
    assign prev_o     = prev_q;

    // R1: the first sample after reset is standby
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_mode == MODE_STANDBY && prev_q.mode == MODE_STANDBY));

endmodule

// File: rtl/sram_write_commit.sv
module sram_write_commit
    import sram_emu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bus_mode_e    cur_mode_i,
    input  held_sample_t prev_i,
    output commit_t      commit_o
);

    logic overlap_end;

    // The overlap closes on the first sample that is no longer a write.
    assign overlap_end = (prev_i.mode == MODE_WRITE) && (cur_mode_i != MODE_WRITE);

    always_comb begin
        commit_o.valid = overlap_end;
        commit_o.addr  = prev_i.addr;
        commit_o.data  = prev_i.data;
    end

    // R6: every store is separated by at least one write sample
    a_r6_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit_o.valid |=> !commit_o.valid);

    // R7: a store is only made straight after a write-mode sample
    a_r7_commit_needs_write: assert property (@(posedge clk) disable iff (rst)
        commit_o.valid |-> $past(cur_mode_i) == MODE_WRITE);

endmodule

// File: rtl/sram_word_store.sv
module sram_word_store
    import sram_emu_pkg::*;
#(
    parameter int DEPTH = 1024
)(
    input  logic              clk,
    input  logic              rst,
    input  commit_t           commit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic              same_word;

    assign wr_idx = commit_i.addr[IDX_W-1:0];
    assign rd_idx = rd_addr_i[IDX_W-1:0];

    generate
        if (IDX_W < ADDR_W) begin : g_alias
            logic unused_high_bits;
            assign unused_high_bits = ^{rd_addr_i[ADDR_W-1:IDX_W],
                                        commit_i.addr[ADDR_W-1:IDX_W]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst && commit_i.valid)
            mem[wr_idx] <= commit_i.data;
    end

    // A read on the closing sample sees the byte being stored.
    assign same_word = commit_i.valid && (wr_idx == rd_idx);
    assign rd_data_o = same_word ? commit_i.data : mem[rd_idx];

    // R6: the committed byte lands at the committed word
    a_r6_stored: assert property (@(posedge clk) disable iff (rst)
        commit_i.valid |=> mem[$past(wr_idx)] == $past(commit_i.data));

endmodule

// File: rtl/sram_out_ctrl.sv
module sram_out_ctrl
    import sram_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         cur_mode_i,
    input  logic              cur_drv_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              oe_o,
    output logic              clash_o
);

    logic [DATA_W-1:0] data_q;
    logic              oe_q;
    logic              clash_q;
    logic              driving;

    assign driving = (cur_mode_i == MODE_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            oe_q    <= 1'b0;
            clash_q <= 1'b0;
        end else begin
            data_q  <= driving ? rd_data_i : '0;
            oe_q    <= driving;
            clash_q <= driving && cur_drv_i;
        end
    end

    assign rdata_o = data_q;
    assign oe_o    = oe_q;
    assign clash_o = clash_q;

    // R2: standby keeps the driver off
    a_r2_standby_off: assert property (@(posedge clk) disable iff (rst)
        cur_mode_i == MODE_STANDBY |=> !oe_o);

    // R4: output-disabled read keeps the driver off
    a_r4_disabled_off: assert property (@(posedge clk) disable iff (rst)
        cur_mode_i == MODE_OUT_OFF |=> !oe_o);

    // R5: write mode keeps the driver off
    a_r5_write_off: assert property (@(posedge clk) disable iff (rst)
        cur_mode_i == MODE_WRITE |=> !oe_o);

    // R10: a clash needs the emulated driver on
    a_r10_clash_needs_oe: assert property (@(posedge clk) disable iff (rst)
        clash_o |-> oe_o);

    // R11: no data shows while the driver is off
    a_r11_quiet_data: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> rdata_o == '0);

endmodule

// File: rtl/sram_pin_model.sv
module sram_pin_model
    import sram_emu_pkg::*;
#(
    parameter int DEPTH = 1024
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_en_n,
    input  logic              wr_n,
    input  logic [18:0]       addr,
    input  logic [7:0]        wdata,
    input  logic              ctl_drive_en,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              bus_clash
);

    pin_sample_t       pins;
    bus_mode_e         cur_mode;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_drv;
    held_sample_t      prev;
    commit_t           commit;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        pins.sel_n   = sel_n;
        pins.rd_en_n = rd_en_n;
        pins.wr_n    = wr_n;
        pins.ctl_drv = ctl_drive_en;
        pins.addr    = addr;
        pins.data    = wdata;
    end

    sram_pin_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins),
        .cur_mode_o (cur_mode),
        .cur_addr_o (cur_addr),
        .cur_drv_o  (cur_drv),
        .prev_o     (prev)
    );

    sram_write_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .cur_mode_i (cur_mode),
        .prev_i     (prev),
        .commit_o   (commit)
    );

    sram_word_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .rd_addr_i (cur_addr),
        .rd_data_o (rd_data)
    );

    sram_out_ctrl u_out (
        .clk        (clk),
        .rst        (rst),
        .cur_mode_i (cur_mode),
        .cur_drv_i  (cur_drv),
        .rd_data_i  (rd_data),
        .rdata_o    (rdata),
        .oe_o       (rdata_oe),
        .clash_o    (bus_clash)
    );

endmodule

// File: tb/test_sram_pin_model.sv
module test_sram_pin_model;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ctl_drive_en = 1'b0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        bus_clash;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_pin_model #(.DEPTH(1024)) i_sram_pin_model (
        .clk          (clk),
        .rst          (rst),
        .sel_n        (sel_n),
        .rd_en_n      (rd_en_n),
        .wr_n         (wr_n),
        .addr         (addr),
        .wdata        (wdata),
        .ctl_drive_en (ctl_drive_en),
        .rdata        (rdata),
        .rdata_oe     (rdata_oe),
        .bus_clash    (bus_clash)
    );

    typedef struct packed {
        logic        sel_n;
        logic        rd_en_n;
        logic        wr_n;
        logic        drv;
        logic [18:0] addr;
        logic [7:0]  din;
        logic        exp_oe;
        logic        exp_clash;
        logic [7:0]  exp_data;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        //  sel rd  wr  drv addr       din    oe  cl  data   req
        '{1'b0,1'b1,1'b0,1'b0,19'h00005,8'hA5,1'b0,1'b0,8'h00,8'd5},  // R5 write
        '{1'b1,1'b1,1'b1,1'b0,19'h00005,8'h00,1'b0,1'b0,8'h00,8'd2},  // R2 standby ends write
        '{1'b0,1'b0,1'b1,1'b0,19'h00005,8'h00,1'b1,1'b0,8'hA5,8'd3},  // R3 read back
        '{1'b0,1'b1,1'b1,1'b0,19'h00005,8'h00,1'b0,1'b0,8'h00,8'd4},  // R4 output off
        '{1'b0,1'b0,1'b0,1'b0,19'h00010,8'h3C,1'b0,1'b0,8'h00,8'd5},  // R5 write, oe low
        '{1'b0,1'b0,1'b1,1'b0,19'h00010,8'h00,1'b1,1'b0,8'h3C,8'd6},  // R6 ended by wr_n
        '{1'b0,1'b1,1'b0,1'b0,19'h00020,8'h11,1'b0,1'b0,8'h00,8'd5},
        '{1'b1,1'b1,1'b1,1'b0,19'h00020,8'h00,1'b0,1'b0,8'h00,8'd2},
        '{1'b1,1'b0,1'b0,1'b0,19'h00020,8'hFF,1'b0,1'b0,8'h00,8'd2},  // R2 / R7 standby write
        '{1'b0,1'b0,1'b1,1'b0,19'h00020,8'h00,1'b1,1'b0,8'h11,8'd7},  // R7 byte unchanged
        '{1'b0,1'b1,1'b0,1'b0,19'h00440,8'h77,1'b0,1'b0,8'h00,8'd5},
        '{1'b1,1'b1,1'b1,1'b0,19'h00000,8'h00,1'b0,1'b0,8'h00,8'd2},
        '{1'b0,1'b0,1'b1,1'b0,19'h00040,8'h00,1'b1,1'b0,8'h77,8'd9},  // R9 alias
        '{1'b0,1'b0,1'b1,1'b1,19'h00005,8'h00,1'b1,1'b1,8'hA5,8'd10}, // R10 clash
        '{1'b0,1'b1,1'b1,1'b1,19'h00005,8'h00,1'b0,1'b0,8'h00,8'd10}, // R10 no clash
        '{1'b1,1'b1,1'b1,1'b0,19'h00000,8'h00,1'b0,1'b0,8'h00,8'd11}  // R11 quiet
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic r, input logic w,
                         input logic [18:0] a, input logic [7:0] d, input logic dv);
        sel_n = s; rd_en_n = r; wr_n = w; addr = a; wdata = d; ctl_drive_en = dv;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(3);
        // R1: outputs off during reset
        check("R1", "oe in reset", {7'd0, rdata_oe}, 8'h00);
        rst = 1'b0;
        cycles(2);
        check("R1", "oe after reset", {7'd0, rdata_oe}, 8'h00);
        check("R1", "data after reset", rdata, 8'h00);
        check("R1", "clash after reset", {7'd0, bus_clash}, 8'h00);

        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].sel_n, VECS[v].rd_en_n, VECS[v].wr_n,
                  VECS[v].addr, VECS[v].din, VECS[v].drv);
            cycles(3);
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d oe", v),
                  {7'd0, rdata_oe}, {7'd0, VECS[v].exp_oe});
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d data", v),
                  rdata, VECS[v].exp_data);
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d clash", v),
                  {7'd0, bus_clash}, {7'd0, VECS[v].exp_clash});
        end

        // R8 / R6: data changes on the closing sample, read of the same word
        drive(1'b0, 1'b1, 1'b0, 19'h00030, 8'h12, 1'b0);
        cycles(2);
        drive(1'b0, 1'b0, 1'b1, 19'h00030, 8'h99, 1'b0);
        cycles(1);
        check("R3", "oe one edge after read", {7'd0, rdata_oe}, 8'h00);
        cycles(1);
        check("R3", "oe two edges after read", {7'd0, rdata_oe}, 8'h01);
        check("R8", "forwarded byte", rdata, 8'h12);
        cycles(2);
        check("R6", "late data not stored", rdata, 8'h12);

        // R6: overlap ended by sel_n with wr_n still low
        drive(1'b0, 1'b1, 1'b0, 19'h00031, 8'h56, 1'b0);
        cycles(2);
        drive(1'b1, 1'b1, 1'b0, 19'h00031, 8'hAA, 1'b0);
        cycles(2);
        drive(1'b0, 1'b0, 1'b1, 19'h00031, 8'h00, 1'b0);
        cycles(3);
        check("R6", "sel_n ended write", rdata, 8'h56);

        // R1: reset during a write discards it
        drive(1'b0, 1'b1, 1'b0, 19'h00031, 8'hEE, 1'b0);
        cycles(2);
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 19'h00031, 8'h00, 1'b0);
        cycles(2);
        check("R1", "oe during reset", {7'd0, rdata_oe}, 8'h00);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 19'h00031, 8'h00, 1'b0);
        cycles(3);
        check("R1", "write cut by reset", rdata, 8'h56);

        drive(1'b1, 1'b1, 1'b1, 19'h00000, 8'h00, 1'b0);
        cycles(3);
        check("R11", "quiet after standby", rdata, 8'h00);
        finish_run();
    end

endmodule